// File: doc/BRIEF.md
# Bus-Mapped Event Register Slave with Interrupt

This block is a template peripheral for a simple synchronous register bus driven by a 16-bit processor core. The bus carries an 8-bit word address, 16-bit write and read data, an active-high enable and a 2-bit active-high byte strobe. The slave decodes a window of four word registers at a parameterised base address. The registers are a control word, a status word holding an event flag, a general data word and a free-running counter.

A counter wrap raises the event flag. The flag drives an interrupt request when interrupts are enabled. Software clears the flag by writing one to it. The flag is also cleared in hardware when the core returns an interrupt-accepted pulse. Read data is produced combinationally in the cycle the enable is high. It stays at zero whenever the slave is not selected, so the read buses of several such slaves can be combined with a plain OR.

Top module: `evt_regslave`

## Requirements
- R1: After reset, all four registers read as zero and irq_req is low.
- R2: The registers sit at word addresses BASE+0 (control), BASE+1 (status), BASE+2 (data) and BASE+3 (counter). BASE defaults to 0x40 and must be a multiple of 4. The byte address seen by the core is twice the word address.
- R3: A write with bus_en high takes effect at the next rising clock edge. A read returns the register value on bus_rdata in the same cycle that bus_en is high.
- R4: Strobe bit 0 writes bits 7:0 and strobe bit 1 writes bits 15:8. A byte whose strobe is low keeps its old value.
- R5: bus_rdata is zero when bus_en is low or the address is outside the four-word window. A write outside the window changes no register.
- R6: Control bit 0 is the interrupt enable and control bit 1 is the counter run enable. All other control bits read as zero.
- R7: While run is set, the counter increments by one every cycle. It holds its value while run is clear. A bus write loads it byte-wise, and a load takes precedence over counting.
- R8: When the counter steps from all ones to zero, the pending flag sets. The pending flag is status bit 0.
- R9: Writing 1 to status bit 0 with strobe bit 0 set clears the pending flag. Writing 0, or writing with only strobe bit 1, leaves the flag unchanged.
- R10: irq_req is high exactly when the pending flag and the interrupt enable are both set.
- R11: A high irq_ack at a clock edge clears the pending flag.
- R12: If a counter wrap coincides with a software or hardware clear, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| bus_en | input | 1 | Bus access enable, active high |
| bus_addr | input | AW | Word address |
| bus_wdata | input | 16 | Write data |
| bus_wstrb | input | 2 | Byte write strobes, active high; all zero means a read |
| bus_rdata | output | 16 | Combinational read data, zero when not selected |
| irq_req | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt accepted by the core for this line |

## Verification
The data register is written with a full word, then with only the low-byte strobe and then with only the high-byte strobe. This separates a correct byte merge from one that ignores strobes or swaps the byte lanes. Reads are issued with the enable low, and at an address just beyond the window, so that leaking read data or a loose decode shows up as a nonzero value. The counter is preset just below its wrap, and the pending flag is then cleared in several ways: a write-1, a write-0, a high-byte-only write, an irq_ack pulse, and an irq_ack pulse timed to coincide with the wrap. Together these distinguish the clear rules from each other and confirm that a set wins over a simultaneous clear.

// File: rtl/evt_regslave.sv
module evt_regslave #(
  parameter int AW = 8,
  parameter logic [AW-1:0] BASE = 'h40,
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_en,
  input  logic [AW-1:0] bus_addr,
  input  logic [15:0]   bus_wdata,
  input  logic [1:0]    bus_wstrb,
  output logic [15:0]   bus_rdata,
  output logic          irq_req,
  input  logic          irq_ack
);
  localparam int OFF_W = 2;
  localparam logic [OFF_W-1:0] OFF_CTRL = 2'd0;
  localparam logic [OFF_W-1:0] OFF_STAT = 2'd1;
  localparam logic [OFF_W-1:0] OFF_DATA = 2'd2;
  localparam logic [OFF_W-1:0] OFF_CNT  = 2'd3;
  localparam logic [CNT_W-1:0] CNT_TOP  = {CNT_W{1'b1}};

  logic             hit, is_wr;
  logic [OFF_W-1:0] off;
  logic             wr_ctrl, wr_stat, wr_data, wr_cnt;
  logic             ctrl_ie, ctrl_run, pend;
  logic [15:0]      data_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_evt, sw_clr;
  logic [15:0]      cnt_merge;

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                        input logic [1:0] strb);
    return {strb[1] ? nw[15:8] : old[15:8], strb[0] ? nw[7:0] : old[7:0]};
  endfunction

  assign hit     = bus_en && (bus_addr[AW-1:OFF_W] == BASE[AW-1:OFF_W]);
  assign off     = bus_addr[OFF_W-1:0];
  assign is_wr   = hit && (bus_wstrb != 2'b00);
  assign wr_ctrl = is_wr && (off == OFF_CTRL);
  assign wr_stat = is_wr && (off == OFF_STAT);
  assign wr_data = is_wr && (off == OFF_DATA);
  assign wr_cnt  = is_wr && (off == OFF_CNT);

  assign cnt_merge = merge(16'(cnt_q), bus_wdata, bus_wstrb);
  assign ovf_evt   = ctrl_run && !wr_cnt && (cnt_q == CNT_TOP);
  assign sw_clr    = wr_stat && bus_wstrb[0] && bus_wdata[0];
  assign irq_req   = pend && ctrl_ie;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ctrl_ie  <= 1'b0;
      ctrl_run <= 1'b0;
    end else if (wr_ctrl && bus_wstrb[0]) begin
      ctrl_ie  <= bus_wdata[0];
      ctrl_run <= bus_wdata[1];
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)          data_q <= '0;
    else if (wr_data) data_q <= merge(data_q, bus_wdata, bus_wstrb);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)           cnt_q <= '0;
    else if (wr_cnt)   cnt_q <= cnt_merge[CNT_W-1:0];
    else if (ctrl_run) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                     pend <= 1'b0;
    else if (ovf_evt)            pend <= 1'b1;
    else if (sw_clr || irq_ack)  pend <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      case (off)
        OFF_CTRL: bus_rdata = {14'd0, ctrl_run, ctrl_ie};
        OFF_STAT: bus_rdata = {15'd0, pend};
        OFF_DATA: bus_rdata = data_q;
        default:  bus_rdata = 16'(cnt_q);
      endcase
    end
  end

  p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !bus_en |-> (bus_rdata == 16'd0));
  p_data_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_data |=> $stable(data_q));
  p_count_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_run && !wr_cnt) |=> $stable(cnt_q));
  p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
    (sw_clr && !ovf_evt) |=> !pend);
  p_ack_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !ovf_evt) |=> !pend);
  p_set_wins_r12: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> pend);
endmodule

// File: tb/evt_regslave_test.sv
`timescale 1ns/1ps
module evt_regslave_test;
  logic        clk = 0, rst = 1;
  logic        bus_en = 0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [1:0]  bus_wstrb = '0;
  logic [15:0] bus_rdata;
  logic        irq_req;
  logic        irq_ack = 0;

  localparam logic [7:0] A_CTRL = 8'h40, A_STAT = 8'h41, A_DATA = 8'h42, A_CNT = 8'h43;

  typedef struct { bit is_irq; logic [15:0] exp; string tag; } item_t;
  item_t q[$];
  event smp;
  int checks = 0, errors = 0;
  bit done = 0;

  evt_regslave uut (.clk(clk), .rst(rst), .bus_en(bus_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_ack(irq_ack));

  always #4 clk = ~clk;

  always @(smp) begin
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      act = it.is_irq ? {15'd0, irq_req} : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] s);
    @(negedge clk);
    bus_en = 1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    @(negedge clk);
    bus_en = 0; bus_wstrb = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic en, input logic [15:0] e, input string t);
    item_t it;
    @(negedge clk);
    bus_en = en; bus_addr = a; bus_wstrb = 0;
    #2;
    it.is_irq = 0; it.exp = e; it.tag = t;
    q.push_back(it);
    ->smp;
    #1 bus_en = 0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    item_t it;
    @(negedge clk);
    #2;
    it.is_irq = 1; it.exp = {15'd0, e}; it.tag = t;
    q.push_back(it);
    ->smp;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    rd(A_CTRL, 1, 16'h0000, "R1 ctrl reset");
    rd(A_STAT, 1, 16'h0000, "R1 stat reset");
    rd(A_DATA, 1, 16'h0000, "R1 data reset");
    rd(A_CNT,  1, 16'h0000, "R1 count reset");
    chk_irq(0, "R1 irq reset");

    wr(A_DATA, 16'hA55A, 2'b11);
    rd(A_DATA, 1, 16'hA55A, "R3 R2 full word data");
    wr(A_DATA, 16'h1234, 2'b01);
    rd(A_DATA, 1, 16'hA534, "R4 low byte strobe");
    wr(A_DATA, 16'hBE00, 2'b10);
    rd(A_DATA, 1, 16'hBE34, "R4 high byte strobe");

    rd(8'h44, 1, 16'h0000, "R5 outside window");
    rd(A_DATA, 0, 16'h0000, "R5 enable low");
    wr(8'h46, 16'hFFFF, 2'b11);
    rd(A_DATA, 1, 16'hBE34, "R5 write outside ignored");

    wr(A_CTRL, 16'hFFFF, 2'b11);
    rd(A_CTRL, 1, 16'h0003, "R6 control bits");
    wr(A_CTRL, 16'h0000, 2'b11);

    wr(A_CNT, 16'h1234, 2'b11);
    rd(A_CNT, 1, 16'h1234, "R7 counter load");
    repeat (3) @(negedge clk);
    rd(A_CNT, 1, 16'h1234, "R7 counter holds");
    wr(A_CNT, 16'h0010, 2'b11);
    wr(A_CTRL, 16'h0002, 2'b11);
    rd(A_CNT, 1, 16'h0011, "R7 counter increments");
    wr(A_CTRL, 16'h0000, 2'b11);

    wr(A_CNT, 16'hFFFE, 2'b11);
    wr(A_CTRL, 16'h0002, 2'b11);
    rd(A_STAT, 1, 16'h0000, "R8 no flag before wrap");
    rd(A_STAT, 1, 16'h0001, "R8 flag on wrap");
    chk_irq(0, "R10 irq gated by enable");
    wr(A_CTRL, 16'h0001, 2'b11);
    chk_irq(1, "R10 irq with enable");

    wr(A_STAT, 16'h0000, 2'b11);
    rd(A_STAT, 1, 16'h0001, "R9 write zero keeps flag");
    wr(A_STAT, 16'h0001, 2'b10);
    rd(A_STAT, 1, 16'h0001, "R9 high strobe only keeps flag");
    wr(A_STAT, 16'h0001, 2'b01);
    rd(A_STAT, 1, 16'h0000, "R9 write one clears");
    chk_irq(0, "R10 irq drops after clear");

    wr(A_CNT, 16'hFFFF, 2'b11);
    wr(A_CTRL, 16'h0003, 2'b11);
    rd(A_STAT, 1, 16'h0001, "R8 wrap from all ones");
    wr(A_CTRL, 16'h0001, 2'b11);
    @(negedge clk) irq_ack = 1;
    @(negedge clk) irq_ack = 0;
    rd(A_STAT, 1, 16'h0000, "R11 ack clears flag");
    chk_irq(0, "R11 irq low after ack");

    wr(A_CNT, 16'hFFFF, 2'b11);
    wr(A_CTRL, 16'h0003, 2'b11);
    irq_ack = 1;
    @(negedge clk) irq_ack = 0;
    rd(A_STAT, 1, 16'h0001, "R12 set wins over ack");
    chk_irq(1, "R12 irq stays high");

    repeat (2) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule